// File: doc/BRIEF.md
# Program Counter and Stack Branch Unit

This block holds the 16-bit program counter and the 16-bit stack pointer of a small byte-oriented processor core and carries out every control-transfer operation on them. The surrounding core decodes an instruction, presents an operation code, a condition selector, the current flags, a 16-bit target, the HL register pair and a restart index, and pulses `start`. The block then updates PC and SP. When a return address must be saved or restored, it drives a byte-wide memory port.

Return addresses live on a downward-growing stack in memory and move one byte per clock. Calls and restarts write the high byte first and then the low byte. Returns read the low byte first and then the high byte. Single-cycle operations finish on the edge that accepts them. Stack operations take three edges. `done` is high for the cycle after the edge that finishes an operation, and `busy` is high while a stack transfer is in progress. The memory port assumes a memory whose read data is valid in the same cycle as the address.

Top module: `pcsp_branch_unit`

## Requirements
- R1: While reset is asserted, and after it is released, PC reads 0x0000 and SP reads 0xFFFF, with `done`, `busy`, `mem_we` and `mem_re` all low. This holds even if reset arrives in the middle of a stack transfer.
- R2: Operation codes are: 0 jump, 1 conditional jump, 2 call, 3 conditional call, 4 return, 5 conditional return, 6 restart, 7 PC from HL, 8 SP from HL. An unconditional jump loads PC with `target` in one cycle and leaves SP unchanged.
- R3: `cond[2:1]` picks the flag: 00 Z, 01 CY, 10 P (parity even), 11 S. The condition is true when that flag equals `cond[0]`. A conditional jump loads `target` when the condition is true. Otherwise it sets PC to PC+3.
- R4: A call (or a true conditional call) pushes PC+3 and then loads `target`. In the first write cycle SP is decremented and the high byte is written at the new SP. In the second write cycle SP is decremented again and the low byte is written. `done` follows the third edge.
- R5: A return (or a true conditional return) reads the low byte at SP and then the high byte at SP+1. SP is incremented after each read, and PC is loaded with the 16-bit value read. The operation takes three edges.
- R6: A conditional call whose condition is false sets PC to PC+3. A conditional return whose condition is false sets PC to PC+1. In both cases there is no memory access, SP is unchanged and the operation finishes in one cycle.
- R7: Restart with index n (0 to 7) pushes PC+1 in the same way as a call and loads PC with n×8.
- R8: PC-from-HL loads PC with `hl`. SP-from-HL loads SP with `hl` and sets PC to PC+1. Each takes one cycle.
- R9: While `busy` is high, `start` is ignored, and PC holds its value until the final edge of the stack transfer.
- R10: Operation codes 9 to 15 finish in one cycle and leave PC and SP unchanged.
- R11: PC, SP and the pushed return address wrap modulo 2^16. This applies to both push and pop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | Begin an operation (sampled while idle) |
| op | input | 4 | Operation code |
| cond | input | 3 | Condition selector |
| flag_cy | input | 1 | Carry flag |
| flag_z | input | 1 | Zero flag |
| flag_s | input | 1 | Sign flag |
| flag_p | input | 1 | Parity-even flag |
| target | input | 16 | Jump or call destination |
| hl | input | 16 | HL register pair value |
| rst_idx | input | 3 | Restart index n |
| mem_rdata | input | 8 | Memory read data, valid in the same cycle |
| pc | output | 16 | Program counter |
| sp | output | 16 | Stack pointer |
| mem_addr | output | 16 | Memory byte address |
| mem_wdata | output | 8 | Memory write data |
| mem_we | output | 1 | Memory write strobe |
| mem_re | output | 1 | Memory read strobe |
| done | output | 1 | Operation finished (one-cycle pulse) |
| busy | output | 1 | Stack transfer in progress |

## Verification
Conditional jumps are tried under all eight selector values. Each selector is run once with its flag set so the condition is true and once with the flag arranged so it is false, which separates a correct flag choice from a swapped or inverted one.

Calls, restarts and returns are interleaved so that a return must recover a byte pair written by an earlier push. This exposes a swapped byte order or an off-by-one SP. The same stack sequences are repeated with SP and PC placed right at the 16-bit boundary to expose wrap faults.

False conditional calls and returns are counted at the memory port. This tells a truly skipped stack access apart from one that was only hidden.

// File: rtl/pcsp_pkg.sv
package pcsp_pkg;
  localparam logic [3:0] OP_JMP  = 4'd0;
  localparam logic [3:0] OP_JCC  = 4'd1;
  localparam logic [3:0] OP_CALL = 4'd2;
  localparam logic [3:0] OP_CCC  = 4'd3;
  localparam logic [3:0] OP_RET  = 4'd4;
  localparam logic [3:0] OP_RCC  = 4'd5;
  localparam logic [3:0] OP_RST  = 4'd6;
  localparam logic [3:0] OP_PCHL = 4'd7;
  localparam logic [3:0] OP_SPHL = 4'd8;

  typedef enum logic [2:0] {
    S_IDLE    = 3'd0,
    S_PUSH_HI = 3'd1,
    S_PUSH_LO = 3'd2,
    S_POP_LO  = 3'd3,
    S_POP_HI  = 3'd4
  } seq_state_e;
endpackage

// File: rtl/pcsp_rst_sync.sv
module pcsp_rst_sync (
  input  logic clk,
  input  logic rst_ni,
  output logic rst_sync_no
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) sync_q <= 2'b00;
    else         sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_no = sync_q[1];
endmodule

// File: rtl/pcsp_cond_eval.sv
module pcsp_cond_eval (
  input  logic [2:0] cond_sel,
  input  logic       fl_cy,
  input  logic       fl_z,
  input  logic       fl_s,
  input  logic       fl_p,
  output logic       cond_true
);
  logic picked;

  always_comb begin
    unique case (cond_sel[2:1])
      2'b00:   picked = fl_z;
      2'b01:   picked = fl_cy;
      2'b10:   picked = fl_p;
      default: picked = fl_s;
    endcase
    cond_true = (picked == cond_sel[0]);
  end
endmodule

// File: rtl/pcsp_addr_calc.sv
module pcsp_addr_calc #(
  parameter int AW        = 16,
  parameter int VEC_SHIFT = 3
) (
  input  logic [3:0]    op,
  input  logic [AW-1:0] pc_cur,
  input  logic [2:0]    rst_idx,
  output logic [AW-1:0] pc_seq,
  output logic [AW-1:0] rst_vec
);
  import pcsp_pkg::*;

  logic [1:0] ilen;

  always_comb begin
    if (op == OP_JMP || op == OP_JCC || op == OP_CALL || op == OP_CCC) ilen = 2'd3;
    else                                                               ilen = 2'd1;
    pc_seq  = pc_cur + AW'(ilen);
    rst_vec = AW'(rst_idx) << VEC_SHIFT;
  end
endmodule

// File: rtl/pcsp_seq.sv
module pcsp_seq #(
  parameter int          AW     = 16,
  parameter logic [15:0] PC_RST = 16'h0000,
  parameter logic [15:0] SP_RST = 16'hFFFF
) (
  input  logic            clk,
  input  logic            rst_ni,
  input  logic            start,
  input  logic [3:0]      op,
  input  logic            cond_true,
  input  logic [AW-1:0]   target,
  input  logic [AW-1:0]   hl,
  input  logic [AW-1:0]   pc_seq,
  input  logic [AW-1:0]   rst_vec,
  input  logic [AW/2-1:0] mem_rdata,
  output logic [AW-1:0]   pc,
  output logic [AW-1:0]   sp,
  output logic [AW-1:0]   mem_addr,
  output logic [AW/2-1:0] mem_wdata,
  output logic            mem_we,
  output logic            mem_re,
  output logic            done,
  output logic            busy
);
  import pcsp_pkg::*;

  localparam int DW = AW / 2;
  localparam logic [AW-1:0] ONE = AW'(1);

  seq_state_e    state_q, state_n;
  logic [AW-1:0] pc_q, pc_n, sp_q, sp_n;
  logic [AW-1:0] ret_q, ret_n, dest_q, dest_n;
  logic [DW-1:0] lo_q, lo_n;
  logic          done_q, done_n;
  logic          ld_link, ld_lo;

  always_comb begin
    state_n = state_q;
    pc_n    = pc_q;
    sp_n    = sp_q;
    ret_n   = ret_q;
    dest_n  = dest_q;
    lo_n    = lo_q;
    done_n  = 1'b0;
    ld_link = 1'b0;
    ld_lo   = 1'b0;
    unique case (state_q)
      S_IDLE: begin
        if (start) begin
          unique case (op)
            OP_JMP: begin
              pc_n   = target;
              done_n = 1'b1;
            end
            OP_JCC: begin
              pc_n   = cond_true ? target : pc_seq;
              done_n = 1'b1;
            end
            OP_CALL, OP_CCC: begin
              if (op == OP_CALL || cond_true) begin
                ret_n   = pc_seq;
                dest_n  = target;
                ld_link = 1'b1;
                sp_n    = sp_q - ONE;
                state_n = S_PUSH_HI;
              end else begin
                pc_n   = pc_seq;
                done_n = 1'b1;
              end
            end
            OP_RST: begin
              ret_n   = pc_seq;
              dest_n  = rst_vec;
              ld_link = 1'b1;
              sp_n    = sp_q - ONE;
              state_n = S_PUSH_HI;
            end
            OP_RET, OP_RCC: begin
              if (op == OP_RET || cond_true) begin
                state_n = S_POP_LO;
              end else begin
                pc_n   = pc_seq;
                done_n = 1'b1;
              end
            end
            OP_PCHL: begin
              pc_n   = hl;
              done_n = 1'b1;
            end
            OP_SPHL: begin
              sp_n   = hl;
              pc_n   = pc_seq;
              done_n = 1'b1;
            end
            default: done_n = 1'b1;
          endcase
        end
      end
      S_PUSH_HI: begin
        sp_n    = sp_q - ONE;
        state_n = S_PUSH_LO;
      end
      S_PUSH_LO: begin
        pc_n    = dest_q;
        done_n  = 1'b1;
        state_n = S_IDLE;
      end
      S_POP_LO: begin
        lo_n    = mem_rdata;
        ld_lo   = 1'b1;
        sp_n    = sp_q + ONE;
        state_n = S_POP_HI;
      end
      S_POP_HI: begin
        pc_n    = {mem_rdata, lo_q};
        sp_n    = sp_q + ONE;
        done_n  = 1'b1;
        state_n = S_IDLE;
      end
      default: state_n = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      pc_q    <= PC_RST[AW-1:0];
      sp_q    <= SP_RST[AW-1:0];
      done_q  <= 1'b0;
    end else begin
      state_q <= state_n;
      pc_q    <= pc_n;
      sp_q    <= sp_n;
      done_q  <= done_n;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      ret_q  <= '0;
      dest_q <= '0;
    end else if (ld_link) begin
      ret_q  <= ret_n;
      dest_q <= dest_n;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni)    lo_q <= '0;
    else if (ld_lo) lo_q <= lo_n;
  end

  assign pc        = pc_q;
  assign sp        = sp_q;
  assign mem_addr  = sp_q;
  assign mem_we    = (state_q == S_PUSH_HI) || (state_q == S_PUSH_LO);
  assign mem_re    = (state_q == S_POP_LO) || (state_q == S_POP_HI);
  assign mem_wdata = (state_q == S_PUSH_HI) ? ret_q[AW-1:DW] : ret_q[DW-1:0];
  assign done      = done_q;
  assign busy      = (state_q != S_IDLE);

  // second push byte goes one below the first
  assert_push_dec_R4: assert property (@(posedge clk) disable iff (!rst_ni)
    (state_q == S_PUSH_LO) |-> (sp_q == $past(sp_q) - ONE));

  // each pop read advances SP by one
  assert_pop_inc_R5: assert property (@(posedge clk) disable iff (!rst_ni)
    (state_q == S_POP_HI) |=> ((sp_q == $past(sp_q) + ONE) && done_q));

  // a false conditional call/return touches neither memory nor SP
  assert_skip_nostack_R6: assert property (@(posedge clk) disable iff (!rst_ni)
    ((state_q == S_IDLE) && start && ((op == OP_CCC) || (op == OP_RCC)) && !cond_true)
      |=> ((sp_q == $past(sp_q)) && !mem_we && !mem_re && done_q));

  // PC is held during the early transfer cycles regardless of start
  assert_busy_hold_R9: assert property (@(posedge clk) disable iff (!rst_ni)
    ((state_q == S_PUSH_HI) || (state_q == S_POP_LO)) |=> $stable(pc_q));
endmodule

// File: rtl/pcsp_branch_unit.sv
module pcsp_branch_unit #(
  parameter int          AW        = 16,
  parameter int          VEC_SHIFT = 3,
  parameter logic [15:0] PC_RST    = 16'h0000,
  parameter logic [15:0] SP_RST    = 16'hFFFF
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [3:0]    op,
  input  logic [2:0]    cond,
  input  logic          flag_cy,
  input  logic          flag_z,
  input  logic          flag_s,
  input  logic          flag_p,
  input  logic [15:0]   target,
  input  logic [15:0]   hl,
  input  logic [2:0]    rst_idx,
  input  logic [7:0]    mem_rdata,
  output logic [15:0]   pc,
  output logic [15:0]   sp,
  output logic [15:0]   mem_addr,
  output logic [7:0]    mem_wdata,
  output logic          mem_we,
  output logic          mem_re,
  output logic          done,
  output logic          busy
);
  logic          rst_sync_n;
  logic          cond_true;
  logic [AW-1:0] pc_seq, rst_vec;

  pcsp_rst_sync u_rst (
    .clk         (clk),
    .rst_ni      (rst_n),
    .rst_sync_no (rst_sync_n)
  );

  pcsp_cond_eval u_cond (
    .cond_sel  (cond),
    .fl_cy     (flag_cy),
    .fl_z      (flag_z),
    .fl_s      (flag_s),
    .fl_p      (flag_p),
    .cond_true (cond_true)
  );

  pcsp_addr_calc #(.AW(AW), .VEC_SHIFT(VEC_SHIFT)) u_addr (
    .op      (op),
    .pc_cur  (pc),
    .rst_idx (rst_idx),
    .pc_seq  (pc_seq),
    .rst_vec (rst_vec)
  );

  pcsp_seq #(.AW(AW), .PC_RST(PC_RST), .SP_RST(SP_RST)) u_seq (
    .clk       (clk),
    .rst_ni    (rst_sync_n),
    .start     (start),
    .op        (op),
    .cond_true (cond_true),
    .target    (target),
    .hl        (hl),
    .pc_seq    (pc_seq),
    .rst_vec   (rst_vec),
    .mem_rdata (mem_rdata),
    .pc        (pc),
    .sp        (sp),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_we    (mem_we),
    .mem_re    (mem_re),
    .done      (done),
    .busy      (busy)
  );
endmodule

// File: tb/sim_pcsp_branch_unit.sv
module sim_pcsp_branch_unit;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 20;

  // fields: op, cond, flags{cy,z,s,p}, target, hl, ridx, exp_pc, exp_sp, exp_cycles
  localparam logic [79:0] VEC [NVEC] = '{
    {4'd0, 3'd0, 4'b0000, 16'h1234, 16'h0000, 3'd0, 16'h1234, 16'hFFFF, 2'd1},
    {4'd1, 3'd1, 4'b0100, 16'h2000, 16'h0000, 3'd0, 16'h2000, 16'hFFFF, 2'd1},
    {4'd1, 3'd1, 4'b0000, 16'h2100, 16'h0000, 3'd0, 16'h2003, 16'hFFFF, 2'd1},
    {4'd1, 3'd2, 4'b0000, 16'h3000, 16'h0000, 3'd0, 16'h3000, 16'hFFFF, 2'd1},
    {4'd1, 3'd3, 4'b0000, 16'h3100, 16'h0000, 3'd0, 16'h3003, 16'hFFFF, 2'd1},
    {4'd1, 3'd5, 4'b0001, 16'h3100, 16'h0000, 3'd0, 16'h3100, 16'hFFFF, 2'd1},
    {4'd1, 3'd4, 4'b0001, 16'h3200, 16'h0000, 3'd0, 16'h3103, 16'hFFFF, 2'd1},
    {4'd1, 3'd7, 4'b0010, 16'h3200, 16'h0000, 3'd0, 16'h3200, 16'hFFFF, 2'd1},
    {4'd1, 3'd6, 4'b0010, 16'h3300, 16'h0000, 3'd0, 16'h3203, 16'hFFFF, 2'd1},
    {4'd1, 3'd0, 4'b0000, 16'h3300, 16'h0000, 3'd0, 16'h3300, 16'hFFFF, 2'd1},
    {4'd2, 3'd0, 4'b0000, 16'h4000, 16'h0000, 3'd0, 16'h4000, 16'hFFFD, 2'd3},
    {4'd6, 3'd0, 4'b0000, 16'h0000, 16'h0000, 3'd5, 16'h0028, 16'hFFFB, 2'd3},
    {4'd4, 3'd0, 4'b0000, 16'h0000, 16'h0000, 3'd0, 16'h4001, 16'hFFFD, 2'd3},
    {4'd3, 3'd3, 4'b0000, 16'h7000, 16'h0000, 3'd0, 16'h4004, 16'hFFFD, 2'd1},
    {4'd5, 3'd1, 4'b0000, 16'h0000, 16'h0000, 3'd0, 16'h4005, 16'hFFFD, 2'd1},
    {4'd5, 3'd1, 4'b0100, 16'h0000, 16'h0000, 3'd0, 16'h3303, 16'hFFFF, 2'd3},
    {4'd3, 3'd6, 4'b0000, 16'h5000, 16'h0000, 3'd0, 16'h5000, 16'hFFFD, 2'd3},
    {4'd7, 3'd0, 4'b0000, 16'h0000, 16'h6000, 3'd0, 16'h6000, 16'hFFFD, 2'd1},
    {4'd8, 3'd0, 4'b0000, 16'h0000, 16'h8010, 3'd0, 16'h6001, 16'h8010, 2'd1},
    {4'd9, 3'd0, 4'b0000, 16'h0000, 16'h0000, 3'd0, 16'h6001, 16'h8010, 2'd1}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [3:0]  op = 4'd0;
  logic [2:0]  cond = 3'd0;
  logic        flag_cy = 1'b0, flag_z = 1'b0, flag_s = 1'b0, flag_p = 1'b0;
  logic [15:0] target = 16'h0, hl = 16'h0;
  logic [2:0]  rst_idx = 3'd0;
  logic [7:0]  mem_rdata;
  logic [15:0] pc, sp, mem_addr;
  logic [7:0]  mem_wdata;
  logic        mem_we, mem_re, done, busy;

  logic [7:0]  mem [256] = '{default: 8'h00};
  logic [15:0] wlog_a [16];
  logic [7:0]  wlog_d [16];
  logic [15:0] rlog_a [16];
  int wr_total = 0;
  int rd_total = 0;
  int total = 0;
  int bad = 0;
  int cyc = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pcsp_branch_unit u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .op(op), .cond(cond),
    .flag_cy(flag_cy), .flag_z(flag_z), .flag_s(flag_s), .flag_p(flag_p),
    .target(target), .hl(hl), .rst_idx(rst_idx), .mem_rdata(mem_rdata),
    .pc(pc), .sp(sp), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_we(mem_we), .mem_re(mem_re), .done(done), .busy(busy)
  );

  assign mem_rdata = mem[mem_addr[7:0]];

  always @(posedge clk) begin
    if (mem_we) begin
      mem[mem_addr[7:0]]   <= mem_wdata;
      wlog_a[wr_total[3:0]] <= mem_addr;
      wlog_d[wr_total[3:0]] <= mem_wdata;
      wr_total <= wr_total + 1;
    end
    if (mem_re) begin
      rlog_a[rd_total[3:0]] <= mem_addr;
      rd_total <= rd_total + 1;
    end
  end

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=finished");
    finish_run();
  end

  task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    start = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic do_op(logic [3:0] o, logic [2:0] c, logic [3:0] fl,
                       logic [15:0] tg, logic [15:0] h, logic [2:0] ri);
    op = o; cond = c; {flag_cy, flag_z, flag_s, flag_p} = fl;
    target = tg; hl = h; rst_idx = ri;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cyc = 1;
    while (!done && cyc < 16) begin
      @(negedge clk);
      cyc++;
    end
  endtask

  function automatic string tag_of(logic [3:0] o);
    case (o)
      4'd0: return "R2 jump";
      4'd1: return "R3 cond jump";
      4'd2: return "R4 call";
      4'd3: return "R6 cond call";
      4'd4: return "R5 return";
      4'd5: return "R6 cond return";
      4'd6: return "R7 restart";
      4'd7, 4'd8: return "R8 hl load";
      default: return "R10 unused code";
    endcase
  endfunction

  initial begin
    int w0, r0;
    repeat (3) @(negedge clk);
    // R1 values while held in reset
    chk("R1 pc in reset", pc, 16'h0000);
    chk("R1 sp in reset", sp, 16'hFFFF);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 pc after reset", pc, 16'h0000);
    chk("R1 sp after reset", sp, 16'hFFFF);
    chk("R1 strobes idle", {12'h0, done, busy, mem_we, mem_re}, 16'h0);

    for (int i = 0; i < NVEC; i++) begin
      logic [79:0] v;
      int acc0;
      v = VEC[i];
      acc0 = wr_total + rd_total;
      do_op(v[79:76], v[75:73], v[72:69], v[68:53], v[52:37], v[36:34]);
      chk({tag_of(v[79:76]), " pc"}, pc, v[33:18]);
      chk({tag_of(v[79:76]), " sp"}, sp, v[17:2]);
      chk({tag_of(v[79:76]), " cycles"}, 16'(cyc), 16'(v[1:0]));
      if (v[1:0] == 2'd1)
        chk({tag_of(v[79:76]), " R6 no stack access"}, 16'(wr_total + rd_total - acc0), 16'h0);
    end

    // R11 wrap with R4 byte order: pc FFFF, sp 0001
    do_op(4'd7, 3'd0, 4'b0, 16'h0, 16'hFFFE, 3'd0);
    do_op(4'd8, 3'd0, 4'b0, 16'h0, 16'h0001, 3'd0);
    chk("R11 pc wrap setup", pc, 16'hFFFF);
    w0 = wr_total;
    do_op(4'd2, 3'd0, 4'b0, 16'h1000, 16'h0, 3'd0);
    chk("R4 call pc", pc, 16'h1000);
    chk("R11 sp wrap on push", sp, 16'hFFFF);
    chk("R4 first write addr", wlog_a[w0[3:0]], 16'h0000);
    chk("R4 first write high byte", 16'(wlog_d[w0[3:0]]), 16'h0000);
    chk("R4 second write addr", wlog_a[(w0 + 1) % 16], 16'hFFFF);
    chk("R11 second write low byte", 16'(wlog_d[(w0 + 1) % 16]), 16'h0002);
    r0 = rd_total;
    do_op(4'd4, 3'd0, 4'b0, 16'h0, 16'h0, 3'd0);
    chk("R5 first read addr", rlog_a[r0[3:0]], 16'hFFFF);
    chk("R5 second read addr", rlog_a[(r0 + 1) % 16], 16'h0000);
    chk("R5 return pc", pc, 16'h0002);
    chk("R11 sp wrap on pop", sp, 16'h0001);

    // R7 restart vectors at the index extremes
    do_op(4'd6, 3'd0, 4'b0, 16'hAAAA, 16'h0, 3'd7);
    chk("R7 restart 7 vector", pc, 16'h0038);
    do_op(4'd6, 3'd0, 4'b0, 16'hAAAA, 16'h0, 3'd0);
    chk("R7 restart 0 vector", pc, 16'h0000);
    chk("R7 restart sp", sp, 16'hFFFD);

    // R9 start held high while busy
    op = 4'd2; target = 16'h1111; start = 1'b1;
    @(negedge clk);
    op = 4'd0; target = 16'h7777;
    chk("R9 busy during push", {15'h0, busy}, 16'h0001);
    @(negedge clk);
    start = 1'b0;
    @(negedge clk);
    chk("R9 done after call", {15'h0, done}, 16'h0001);
    chk("R9 pc is call target", pc, 16'h1111);
    repeat (3) @(negedge clk);
    chk("R9 pc unchanged later", pc, 16'h1111);

    // R1 reset in the middle of a push
    op = 4'd2; target = 16'h2222; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    rst_n = 1'b0;
    #1;
    chk("R1 async reset pc", pc, 16'h0000);
    chk("R1 async reset sp", sp, 16'hFFFF);
    chk("R1 async reset strobes", {12'h0, done, busy, mem_we, mem_re}, 16'h0);
    do_reset();
    chk("R1 pc after second reset", pc, 16'h0000);

    finish_run();
  end
endmodule